// File: doc/BRIEF.md
# Multi-Row Feature-Map Line Buffer

This block sits between an incoming AXI4-Stream of convolution data and a group of convolution engines. Each layer pass sends one square kernel of `KSIZE*KSIZE` weight words on the stream, followed by image rows of `ROW_LEN` words each. Nothing on the stream marks where the weights end. The block counts the weight words itself and then switches to filling rows. Every image row lands in its own row bank. This lets each engine pick any held row and column through its own read port, and different engines can read different rows in the same cycle.

The buffer has `KSIZE + STRIDE` banks. Once the weights and `KSIZE` rows are stored, `compute_ready` tells the downstream scheduler it may start. While the scheduler works, the stream keeps filling the `STRIDE` spare banks. When every bank is occupied, the stream is stalled. A `rows_done` pulse from the scheduler releases the `STRIDE` oldest rows. The logical row numbering then rotates, so that the engines keep addressing rows relative to the oldest row still held, and the stream is accepted again.

Top module: `fmap_row_buffer`

## Requirements
- R1: While reset is held and straight after it, `s_tready` is 1, `compute_ready` is 0, and `wt_data` and every `eng_data` lane are 0.
- R2: The first `KSIZE*KSIZE` accepted beats after reset go to the weight store, in arrival order. Weight word k appears on `wt_data` one clock after `wt_addr` = k. An address of `KSIZE*KSIZE` or above reads 0.
- R3: Beats accepted after the weights fill image rows, column 0 first, `ROW_LEN` beats per row. Logical row k is the k-th row received after the oldest row still held.
- R4: `compute_ready` is 1 exactly when all weights are stored and at least `KSIZE` complete rows are held. Storing further rows or leaving the buffer untouched never drops it.
- R5: When all `KSIZE + STRIDE` banks hold complete rows, `s_tready` is 0. It stays 0 until a `rows_done` pulse is accepted.
- R6: A `rows_done` pulse in a cycle where `compute_ready` is 1 releases the `STRIDE` oldest rows. Logical row k then returns the row that was logical row k + `STRIDE`, and `s_tready` is 1 on the next cycle.
- R7: A `rows_done` pulse in a cycle where `compute_ready` is 0 has no effect on the held row count or the row numbering.
- R8: Each engine e has its own row select (`RW` bits at bit e*`RW` of `eng_row`) and column (`CW` bits at bit e*`CW` of `eng_col`). Its data word appears at bits e*`DW` of `eng_data` one clock later. Engines may read the same row or different rows in the same cycle.
- R9: A row select of `KSIZE + STRIDE` or above returns 0 on that engine's lane.
- R10: A beat is stored only in a cycle where both `s_tvalid` and `s_tready` are 1. Data offered while `s_tvalid` is 0 or `s_tready` is 0 is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_tdata | input | DW | Stream data word |
| s_tvalid | input | 1 | Stream word valid |
| s_tready | output | 1 | Buffer can take a word |
| wt_addr | input | WAW | Weight word address |
| wt_data | output | DW | Weight word, one clock after the address |
| eng_row | input | N_ENG*RW | Logical row select, one field per engine |
| eng_col | input | N_ENG*CW | Column address, one field per engine |
| eng_data | output | N_ENG*DW | Read data, one lane per engine, one clock after the address |
| compute_ready | output | 1 | Weights and enough rows are present |
| rows_done | input | 1 | Scheduler has finished with the oldest rows |

## Verification
The bench goes after the weight/row boundary. A counter that is off by one would shift every image word by one column or spill a weight into row 0. It also checks that `compute_ready` rises on the last beat of the `KSIZE`-th row and not earlier.

A full buffer must stall, and data offered during the stall must not be taken. A design that ignores this overwrites the oldest held row.

After a release, the rotated numbering must show the next-oldest row as logical row 0. A `rows_done` pulse that arrives while too few rows are held must leave the count intact. A design that decrements the count anyway would never raise `compute_ready` again after the next row arrives.

Reads by two engines in the same cycle, including from the same row and from out-of-range row selects, confirm that the lanes are independent.

// File: rtl/fmap_row_buffer.sv
module fmap_row_buffer #(
  parameter int DW      = 8,
  parameter int ROW_LEN = 8,
  parameter int KSIZE   = 3,
  parameter int STRIDE  = 1,
  parameter int N_ENG   = 2,
  localparam int NROWS  = KSIZE + STRIDE,
  localparam int WCNT   = KSIZE * KSIZE,
  localparam int WAW    = $clog2(WCNT),
  localparam int CW     = $clog2(ROW_LEN),
  localparam int HW     = $clog2(NROWS),
  localparam int FW     = $clog2(NROWS + 1),
  localparam int RW     = HW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DW-1:0]       s_tdata,
  input  logic                s_tvalid,
  output logic                s_tready,
  input  logic [WAW-1:0]      wt_addr,
  output logic [DW-1:0]       wt_data,
  input  logic [N_ENG*RW-1:0] eng_row,
  input  logic [N_ENG*CW-1:0] eng_col,
  output logic [N_ENG*DW-1:0] eng_data,
  output logic                compute_ready,
  input  logic                rows_done
);

  function automatic logic [HW-1:0] wrap(input logic [HW+1:0] x);
    logic [HW+1:0] y;
    y = (x >= (HW+2)'(NROWS)) ? x - (HW+2)'(NROWS) : x;
    return y[HW-1:0];
  endfunction

  logic [DW-1:0]  wmem [WCNT];
  logic [DW-1:0]  rmem [NROWS][ROW_LEN];
  logic           wt_done;
  logic [WAW-1:0] wcnt;
  logic [CW-1:0]  col;
  logic [HW-1:0]  head;
  logic [FW-1:0]  filled;
  logic [HW-1:0]  wr_bank;

  wire accept  = s_tvalid && s_tready;
  wire row_end = accept && wt_done && (col == CW'(ROW_LEN - 1));
  wire consume = rows_done && compute_ready;

  assign s_tready      = !wt_done || (filled != FW'(NROWS));
  assign compute_ready = wt_done && (filled >= FW'(KSIZE));
  assign wr_bank       = wrap((HW+2)'(head) + (HW+2)'(filled));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wt_done <= 1'b0;
      wcnt    <= '0;
      col     <= '0;
      head    <= '0;
      filled  <= '0;
    end else begin
      if (accept && !wt_done) begin
        wcnt <= wcnt + 1'b1;
        if (wcnt == WAW'(WCNT - 1)) wt_done <= 1'b1;
      end
      if (accept && wt_done) col <= row_end ? '0 : col + 1'b1;
      filled <= filled + FW'(row_end) - (consume ? FW'(STRIDE) : FW'(0));
      if (consume) head <= wrap((HW+2)'(head) + (HW+2)'(STRIDE));
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !wt_done) wmem[wcnt] <= s_tdata;
    if (accept && wt_done) rmem[wr_bank][col] <= s_tdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wt_data <= '0;
    else        wt_data <= (wt_addr < WAW'(WCNT)) ? wmem[wt_addr] : '0;
  end

  for (genvar e = 0; e < N_ENG; e++) begin : g_eng
    wire [RW-1:0] sel = eng_row[e*RW +: RW];
    wire [CW-1:0] c   = eng_col[e*CW +: CW];
    wire [HW-1:0] pb  = wrap((HW+2)'(head) + (HW+2)'(sel));
    wire          ok  = (sel < RW'(NROWS)) && ({1'b0, c} < (CW+1)'(ROW_LEN));
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= ok ? rmem[pb][c] : '0;
    end
    assign eng_data[e*DW +: DW] = q;
  end

endmodule

// File: rtl/fmap_row_buffer_chk.sv
module fmap_row_buffer_chk #(
  parameter int NROWS = 4,
  parameter int KSIZE = 3,
  parameter int HW    = 2,
  parameter int FW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_tready,
  input logic          compute_ready,
  input logic          rows_done,
  input logic          wt_done,
  input logic [HW-1:0] head,
  input logic [FW-1:0] filled
);

  a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    filled <= FW'(NROWS));

  a_r2_no_compute_before_weights: assert property (@(posedge clk) disable iff (!rst_n)
    !wt_done |-> !compute_ready);

  a_r4_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    compute_ready && !rows_done |=> compute_ready);

  a_r5_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    wt_done && filled == FW'(NROWS) |-> !s_tready);

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    wt_done && !s_tready && !rows_done |=> !s_tready);

  a_r6_release_reopens: assert property (@(posedge clk) disable iff (!rst_n)
    compute_ready && rows_done |=> s_tready);

  a_r6_release_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    compute_ready && rows_done |=> head != $past(head));

  a_r7_idle_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !compute_ready && rows_done |=> $stable(head));

endmodule

bind fmap_row_buffer fmap_row_buffer_chk #(
  .NROWS(NROWS), .KSIZE(KSIZE), .HW(HW), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_tready(s_tready), .compute_ready(compute_ready),
  .rows_done(rows_done), .wt_done(wt_done), .head(head), .filled(filled)
);

// File: tb/tb_fmap_row_buffer.sv
module tb_fmap_row_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [3:0]  wt_addr = '0;
  logic [7:0]  wt_data;
  logic [5:0]  eng_row = '0;
  logic [5:0]  eng_col = '0;
  logic [15:0] eng_data;
  logic        compute_ready;
  logic        rows_done = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fmap_row_buffer dut (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .wt_addr(wt_addr), .wt_data(wt_data), .eng_row(eng_row), .eng_col(eng_col),
    .eng_data(eng_data), .compute_ready(compute_ready), .rows_done(rows_done)
  );

  // {row0, col0, row1, col1, expected lane0, expected lane1}; pixel of row n col c = {n, c+1}
  localparam logic [31:0] RD_VEC [8] = '{
    {4'd0, 4'd0, 4'd1, 4'd0, 8'h01, 8'h11},
    {4'd2, 4'd7, 4'd3, 4'd3, 8'h28, 8'h34},
    {4'd3, 4'd7, 4'd0, 4'd5, 8'h38, 8'h06},
    {4'd1, 4'd2, 4'd1, 4'd6, 8'h13, 8'h17},
    {4'd5, 4'd0, 4'd2, 4'd1, 8'h00, 8'h22},
    {4'd4, 4'd3, 4'd7, 4'd7, 8'h00, 8'h00},
    {4'd2, 4'd4, 4'd2, 4'd4, 8'h25, 8'h25},
    {4'd0, 4'd7, 4'd3, 4'd0, 8'h08, 8'h31}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    s_tvalid = 1'b1;
    s_tdata  = d;
    while (!s_tready) @(negedge clk);
    @(posedge clk);
    #1 s_tvalid = 1'b0;
  endtask

  task automatic send_row(input int n);
    for (int c = 0; c < 8; c++) begin
      push(8'((n << 4) + c + 1));
      if (c == 3) begin
        // R10: an idle cycle with junk data while tvalid is low
        @(negedge clk);
        s_tdata = 8'hEE;
      end
    end
  endtask

  task automatic rd(input int r0, input int c0, input int r1, input int c1,
                    output logic [15:0] q);
    @(negedge clk);
    eng_row = {3'(r1), 3'(r0)};
    eng_col = {3'(c1), 3'(c0)};
    @(negedge clk);
    q = eng_data;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    rows_done = 1'b1;
    @(negedge clk);
    rows_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] q;
    repeat (3) @(negedge clk);
    check("R1 tready in reset", 32'(s_tready), 32'd1);
    check("R1 compute_ready in reset", 32'(compute_ready), 32'd0);
    check("R1 eng_data in reset", 32'(eng_data), 32'd0);
    check("R1 wt_data in reset", 32'(wt_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tready after reset", 32'(s_tready), 32'd1);

    for (int i = 0; i < 9; i++) push(8'(8'hA0 + i));
    @(negedge clk);
    check("R4 not ready with weights only", 32'(compute_ready), 32'd0);
    foreach (RD_VEC[i]) begin end
    wt_addr = 4'd0;  @(negedge clk); check("R2 weight 0", 32'(wt_data), 32'hA0);
    wt_addr = 4'd4;  @(negedge clk); check("R2 weight 4", 32'(wt_data), 32'hA4);
    wt_addr = 4'd8;  @(negedge clk); check("R2 weight 8", 32'(wt_data), 32'hA8);
    wt_addr = 4'd12; @(negedge clk); check("R2 weight out of range", 32'(wt_data), 32'h00);

    send_row(0);
    send_row(1);
    @(negedge clk);
    check("R4 not ready with two rows", 32'(compute_ready), 32'd0);
    send_row(2);
    @(negedge clk);
    check("R4 ready on third row", 32'(compute_ready), 32'd1);
    check("R5 spare bank open", 32'(s_tready), 32'd1);
    send_row(3);
    @(negedge clk);
    check("R5 stall when full", 32'(s_tready), 32'd0);
    check("R4 ready stays with spare row", 32'(compute_ready), 32'd1);

    // R10: offer data during the stall
    s_tvalid = 1'b1;
    s_tdata  = 8'hEE;
    repeat (3) @(negedge clk);
    check("R5 stall holds", 32'(s_tready), 32'd0);
    s_tvalid = 1'b0;

    // R3, R8, R9: parallel engine reads over the vector table
    for (int i = 0; i < 8; i++) begin
      rd(int'(RD_VEC[i][31:28]), int'(RD_VEC[i][27:24]),
         int'(RD_VEC[i][23:20]), int'(RD_VEC[i][19:16]), q);
      check($sformatf("R8 vector %0d lane0", i), 32'(q[7:0]), 32'(RD_VEC[i][15:8]));
      check($sformatf("R8 vector %0d lane1", i), 32'(q[15:8]), 32'(RD_VEC[i][7:0]));
    end

    pulse_done();
    check("R6 tready after release", 32'(s_tready), 32'd1);
    check("R4 ready with three rows", 32'(compute_ready), 32'd1);
    rd(0, 0, 2, 7, q);
    check("R6 logical row 0 is old row 1", 32'(q[7:0]), 32'h11);
    check("R6 logical row 2 is old row 3", 32'(q[15:8]), 32'h38);

    send_row(4);
    @(negedge clk);
    check("R5 stall again", 32'(s_tready), 32'd0);
    rd(3, 1, 3, 0, q);
    check("R10 recycled bank col1", 32'(q[7:0]), 32'h42);
    check("R10 recycled bank col0", 32'(q[15:8]), 32'h41);

    pulse_done();
    pulse_done();
    check("R4 not ready with two rows held", 32'(compute_ready), 32'd0);
    pulse_done();
    rd(0, 0, 1, 7, q);
    check("R7 ignored release keeps row 0", 32'(q[7:0]), 32'h31);
    check("R7 ignored release keeps row 1", 32'(q[15:8]), 32'h48);
    send_row(5);
    @(negedge clk);
    check("R7 count kept, ready with new row", 32'(compute_ready), 32'd1);
    rd(2, 0, 2, 7, q);
    check("R3 new row col0", 32'(q[7:0]), 32'h51);
    check("R3 new row col7", 32'(q[15:8]), 32'h58);

    finish_run();
  end
endmodule